// File: doc/BRIEF.md
# Dual-Channel Status Block Reader

This block keeps one full block of channel-status information for two audio subframe channels, named A and B, and gives a host read access to it one byte at a time. Every storage word holds one byte position of the block for both channels: the A byte sits in the upper half and the B byte in the lower half. The receiver side fills the store one byte lane at a time, through a word index and a lane select.

The host picks a read mode with a control bit. In single-lane mode, each transfer returns one byte from the channel chosen by a second control bit. In paired mode, each word is returned as two transfers: the A byte first, then the B byte. A read pointer steps forward by itself and wraps at the end of the block, so a whole block can be streamed after a single address load. Bytes leave through a valid/ready handshake. Each accepted transfer carries exactly one byte, and it comes with a flag that names the lane the byte came from.

Top module: `csb_reader`

## Requirements
- R1: The store holds 24 words of two 8-bit lanes. A write with `wr_lane`=0 updates only the A (upper) lane of word `wr_idx`, and `wr_lane`=1 updates only the B (lower) lane. The other lane of that word keeps its value.
- R2: After reset, `rd_valid` is low, single-lane mode with channel A is selected, and the read pointer is at word 0. Store contents are not cleared by reset.
- R3: In single-lane mode (`cfg_pair`=0), each transfer returns the A byte (`cfg_sel_b`=0) or the B byte (`cfg_sel_b`=1) of the current word, with `rd_lane` equal to `cfg_sel_b`. The pointer advances by one after every accepted byte.
- R4: In paired mode (`cfg_pair`=1), each word yields two transfers: first the A byte with `rd_lane`=0, then the B byte with `rd_lane`=1. The pointer advances only after the B byte is accepted.
- R5: The pointer wraps from word 23 to word 0.
- R6: `addr_we` moves the pointer to `addr_val` and restarts at the A byte. A value from 24 to 31 loads word 0.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_byte` and `rd_lane` stay stable. A byte is consumed only in a cycle where both are high.
- R8: `cfg_we` loads `cfg_pair` and `cfg_sel_b` and withdraws any pending byte (`rd_valid` is low in the next cycle). Reading then restarts at the A byte of the current word, and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver-side byte write strobe |
| wr_lane | input | 1 | Lane to write: 0 = A, 1 = B |
| wr_idx | input | 5 | Word index of the write (0..23) |
| wr_byte | input | 8 | Byte to write |
| cfg_we | input | 1 | Load the mode and channel-select registers |
| cfg_pair | input | 1 | Mode value: 0 = single-lane, 1 = paired A-then-B |
| cfg_sel_b | input | 1 | Channel value for single-lane mode: 0 = A, 1 = B |
| addr_we | input | 1 | Load the read pointer |
| addr_val | input | 5 | New read pointer value |
| rd_ready | input | 1 | Host accepts the presented byte |
| rd_valid | output | 1 | A byte is presented |
| rd_byte | output | 8 | Presented byte |
| rd_lane | output | 1 | Lane of the presented byte: 0 = A, 1 = B |

## Verification
A pointer that is off, or a lane phase that is wrong, shows up on the very next transfer. The byte returned belongs to another word, or it carries the wrong `rd_lane`. For this reason every byte of full-block, wrapped and paired sweeps is compared against a model of the store. Writes that cross into the other lane only become visible when that lane is read, so the lane test reads both halves of the word it touched. A restart that leaves stale state behind shows up one handshake after the control write: the first byte delivered after it is the wrong one.

// File: rtl/csb_pkg.sv
package csb_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_LOAD  = 2'd1,
    ST_HOLD  = 2'd2
  } seq_state_t;

  localparam logic LANE_A = 1'b0;
  localparam logic LANE_B = 1'b1;
endpackage

// File: rtl/csb_store.sv
module csb_store #(
  parameter int WORDS = 24,
  parameter int BW    = 8,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_lane,
  input  logic [AW-1:0] wr_idx,
  input  logic [BW-1:0] wr_byte,
  input  logic [AW-1:0] rd_ptr,
  output logic [BW-1:0] q_a,
  output logic [BW-1:0] q_b
);
  import csb_pkg::*;

  logic [BW-1:0] mem_a [WORDS];
  logic [BW-1:0] mem_b [WORDS];
  logic          idx_ok;

  assign idx_ok = int'(wr_idx) < WORDS;

  // Two read-first RAMs, one per lane, each with a registered read port
  always_ff @(posedge clk) begin
    if (wr_en && idx_ok && wr_lane == LANE_A) mem_a[wr_idx] <= wr_byte;
    q_a <= mem_a[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (wr_en && idx_ok && wr_lane == LANE_B) mem_b[wr_idx] <= wr_byte;
    q_b <= mem_b[rd_ptr];
  end

  // R1
  lane_b_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_ok && wr_lane == LANE_A) |=> mem_b[$past(wr_idx)] == $past(mem_b[wr_idx]));

  // R1
  lane_a_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_ok && wr_lane == LANE_B) |=> mem_a[$past(wr_idx)] == $past(mem_a[wr_idx]));
endmodule

// File: rtl/csb_cfg.sv
module csb_cfg (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_pair,
  input  logic cfg_sel_b,
  output logic pair_mode,
  output logic sel_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_mode <= 1'b0;
      sel_b     <= 1'b0;
    end else if (cfg_we) begin
      pair_mode <= cfg_pair;
      sel_b     <= cfg_sel_b;
    end
  end

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (pair_mode == $past(cfg_pair)) && (sel_b == $past(cfg_sel_b)));
endmodule

// File: rtl/csb_seq.sv
module csb_seq #(
  parameter int WORDS = 24,
  parameter int BW    = 8,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pair_mode,
  input  logic          sel_b,
  input  logic          cfg_we,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_val,
  input  logic [BW-1:0] q_a,
  input  logic [BW-1:0] q_b,
  input  logic          rd_ready,
  output logic [AW-1:0] ptr,
  output logic          rd_valid,
  output logic [BW-1:0] rd_byte,
  output logic          rd_lane
);
  import csb_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  seq_state_t    st;
  logic          phase_b;
  logic          lane_pick;
  logic          restart;
  logic [AW-1:0] next_ptr;
  logic [AW-1:0] load_ptr;

  assign restart   = cfg_we || addr_we;
  assign lane_pick = pair_mode ? phase_b : sel_b;
  assign next_ptr  = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign load_ptr  = (int'(addr_val) < WORDS) ? addr_val : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FETCH;
      ptr      <= '0;
      phase_b  <= 1'b0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
      rd_lane  <= LANE_A;
    end else if (restart) begin
      st       <= ST_FETCH;
      phase_b  <= 1'b0;
      rd_valid <= 1'b0;
      if (addr_we) ptr <= load_ptr;
    end else begin
      case (st)
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          rd_byte  <= lane_pick ? q_b : q_a;
          rd_lane  <= lane_pick;
          rd_valid <= 1'b1;
          st       <= ST_HOLD;
        end
        ST_HOLD: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            st       <= ST_FETCH;
            if (pair_mode && !phase_b) begin
              phase_b <= 1'b1;
            end else begin
              phase_b <= 1'b0;
              ptr     <= next_ptr;
            end
          end
        end
        default: st <= ST_FETCH;
      endcase
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !restart) |=> rd_valid && $stable(rd_byte) && $stable(rd_lane));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && !pair_mode && !restart)
      |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  // R4
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && pair_mode && rd_lane == LANE_A && !restart) |=> $stable(ptr));

  // R8
  restart_drop_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !rd_valid);

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < WORDS);

  // R6
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> ptr == ((int'($past(addr_val)) < WORDS) ? $past(addr_val) : '0));
endmodule

// File: rtl/csb_reader.sv
module csb_reader #(
  parameter int WORDS = 24,
  parameter int BW    = 8,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_lane,
  input  logic [AW-1:0] wr_idx,
  input  logic [BW-1:0] wr_byte,
  input  logic          cfg_we,
  input  logic          cfg_pair,
  input  logic          cfg_sel_b,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_val,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [BW-1:0] rd_byte,
  output logic          rd_lane
);
  logic [AW-1:0] ptr;
  logic [BW-1:0] q_a;
  logic [BW-1:0] q_b;
  logic          pair_mode;
  logic          sel_b;

  csb_store #(.WORDS(WORDS), .BW(BW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_lane (wr_lane),
    .wr_idx  (wr_idx),
    .wr_byte (wr_byte),
    .rd_ptr  (ptr),
    .q_a     (q_a),
    .q_b     (q_b)
  );

  csb_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_pair  (cfg_pair),
    .cfg_sel_b (cfg_sel_b),
    .pair_mode (pair_mode),
    .sel_b     (sel_b)
  );

  csb_seq #(.WORDS(WORDS), .BW(BW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pair_mode (pair_mode),
    .sel_b     (sel_b),
    .cfg_we    (cfg_we),
    .addr_we   (addr_we),
    .addr_val  (addr_val),
    .q_a       (q_a),
    .q_b       (q_b),
    .rd_ready  (rd_ready),
    .ptr       (ptr),
    .rd_valid  (rd_valid),
    .rd_byte   (rd_byte),
    .rd_lane   (rd_lane)
  );
endmodule

// File: tb/csb_reader_test.sv
module csb_reader_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_lane = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [7:0] wr_byte = '0;
  logic       cfg_we = 1'b0;
  logic       cfg_pair = 1'b0;
  logic       cfg_sel_b = 1'b0;
  logic       addr_we = 1'b0;
  logic [4:0] addr_val = '0;
  logic       rd_ready = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_byte;
  logic       rd_lane;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl_a [24];
  logic [7:0] mdl_b [24];

  csb_reader uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lane(wr_lane), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .cfg_we(cfg_we), .cfg_pair(cfg_pair), .cfg_sel_b(cfg_sel_b),
    .addr_we(addr_we), .addr_val(addr_val), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_lane(rd_lane)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic lane, input int idx, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_lane = lane; wr_idx = 5'(idx); wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (lane) mdl_b[idx] = b; else mdl_a[idx] = b;
  endtask

  task automatic set_cfg(input logic pair, input logic selb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pair = pair; cfg_sel_b = selb;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_addr(input logic [4:0] a);
    @(negedge clk);
    addr_we = 1'b1; addr_val = a;
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  // Wait for a presented byte, then accept it with one ready cycle
  task automatic take(output logic [7:0] b, output logic l);
    int n = 0;
    while (!rd_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    b = rd_byte; l = rd_lane;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] eb, input logic el);
    logic [7:0] b;
    logic l;
    take(b, l);
    chk(b == eb && l == el, tag, {l, b}, {el, eb});
  endtask

  task automatic t_reset;
    // R2: fill store while in reset; reset does not clear it
    rst = 1'b1;
    for (int i = 0; i < 24; i++) begin
      wr(1'b0, i, 8'(8'hA0 ^ (i * 3)));
      wr(1'b1, i, 8'(8'h30 + i * 5));
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R2 valid low in reset", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R2 valid low after reset", rd_valid, 0);
    expect_byte("R2 default word0 lane A", mdl_a[0], 1'b0);
    expect_byte("R2 default step lane A", mdl_a[1], 1'b0);
  endtask

  task automatic t_single_a_wrap;
    // R3 and R5: full block of A bytes then wrap to word 0
    set_cfg(1'b0, 1'b0);
    set_addr(5'd0);
    for (int i = 0; i < 24; i++) expect_byte("R3 single lane A sweep", mdl_a[i], 1'b0);
    expect_byte("R5 wrap to word 0", mdl_a[0], 1'b0);
    expect_byte("R5 after wrap word 1", mdl_a[1], 1'b0);
  endtask

  task automatic t_single_b;
    // R3: channel B selection
    set_cfg(1'b0, 1'b1);
    set_addr(5'd5);
    for (int i = 5; i < 9; i++) expect_byte("R3 single lane B", mdl_b[i], 1'b1);
  endtask

  task automatic t_pair;
    // R4 and R5: pairs across the wrap
    set_cfg(1'b1, 1'b0);
    set_addr(5'd22);
    for (int k = 0; k < 3; k++) begin
      int w = (22 + k) % 24;
      expect_byte("R4 pair A first", mdl_a[w], 1'b0);
      expect_byte("R4 pair B second", mdl_b[w], 1'b1);
    end
  endtask

  task automatic t_lane_write;
    // R1: writing lane A leaves lane B of the same word
    wr(1'b0, 9, 8'hEE);
    wr(1'b1, 10, 8'h11);
    set_cfg(1'b1, 1'b0);
    set_addr(5'd9);
    expect_byte("R1 new A byte", 8'hEE, 1'b0);
    expect_byte("R1 B lane kept", mdl_b[9], 1'b1);
    expect_byte("R1 A lane kept", mdl_a[10], 1'b0);
    expect_byte("R1 new B byte", 8'h11, 1'b1);
  endtask

  task automatic t_hold;
    // R7: byte held while ready low
    logic [7:0] b0;
    logic l0;
    set_cfg(1'b0, 1'b0);
    set_addr(5'd12);
    repeat (4) @(negedge clk);
    b0 = rd_byte; l0 = rd_lane;
    chk(rd_valid == 1'b1, "R7 valid presented", rd_valid, 1);
    repeat (6) @(negedge clk);
    chk(rd_valid == 1'b1 && rd_byte == b0 && rd_lane == l0, "R7 held stable",
        {rd_valid, rd_byte}, {1'b1, b0});
    chk(b0 == mdl_a[12], "R7 held byte value", b0, mdl_a[12]);
    expect_byte("R7 single consume", mdl_a[12], 1'b0);
    expect_byte("R7 next after consume", mdl_a[13], 1'b0);
  endtask

  task automatic t_addr_range;
    // R6: out-of-range address loads word 0
    set_cfg(1'b0, 1'b0);
    set_addr(5'd27);
    expect_byte("R6 high address maps to 0", mdl_a[0], 1'b0);
    set_addr(5'd23);
    expect_byte("R6 load 23", mdl_a[23], 1'b0);
  endtask

  task automatic t_cfg_restart;
    // R8: config write restarts at A byte of current word
    set_cfg(1'b1, 1'b0);
    set_addr(5'd3);
    expect_byte("R8 pair A3", mdl_a[3], 1'b0);
    repeat (3) @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pair = 1'b1; cfg_sel_b = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(rd_valid == 1'b0, "R8 pending byte withdrawn", rd_valid, 0);
    expect_byte("R8 restart at A3", mdl_a[3], 1'b0);
    expect_byte("R8 then B3", mdl_b[3], 1'b1);
    set_cfg(1'b0, 1'b1);
    expect_byte("R8 mode switch keeps word", mdl_b[4], 1'b1);
  endtask

  initial begin
    t_reset();
    t_single_a_wrap();
    t_single_b();
    t_pair();
    t_lane_write();
    t_hold();
    t_addr_range();
    t_cfg_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule